// File: doc/BRIEF.md
# Typed Transmit Word Framer

This block builds the outgoing 32-bit word stream of a serial link transmitter. Once per word clock it takes a data word, a two-bit type code and an enable, and produces one registered output word together with a flag that says whether that word went through the scrambler. It sits between the user's parallel transmit interface and the line coder/serialiser, which are outside its scope.

When the enable is low, the input word is ignored and a fixed IDLE pattern is sent. When the enable is high, type code 00 sends a fixed SYNC pattern and restarts an additive PRBS7 scrambler from an all-ones seed. Any of the other three codes marks a normal data word, which is XORed with 32 bits of scrambler keystream. A data word that arrives before any SYNC since reset cannot be scrambled in step with the receiver. It is therefore replaced by IDLE, and a sticky error flag is raised.

Top module: `txw_framer`

## Requirements
- R1: While reset is high and in the first cycle after a reset edge, `word_out` equals IDLE_WORD, `word_scr` is 0 and `lock_err` is 0. Reset also forgets any earlier SYNC.
- R2: The output is registered. The word chosen from the inputs sampled at a rising edge appears on the outputs right after that edge and holds for one word clock.
- R3: With `tx_valid` low, `word_out` becomes IDLE_WORD and `word_scr` becomes 0, whatever `tx_data` and `tx_kind` carry.
- R4: With `tx_valid` high and `tx_kind` = 2'b00, `word_out` becomes SYNC_WORD unscrambled and `word_scr` becomes 0.
- R5: A SYNC word loads the scrambler state with all ones (7'h7F), so the next data word uses the keystream of that seed.
- R6: With `tx_valid` high, `tx_kind` of 2'b01, 2'b10 or 2'b11 and a SYNC seen since reset, `word_out` becomes `tx_data` XOR keystream and `word_scr` becomes 1. The three codes behave the same.
- R7: The keystream runs 32 steps of state s[6:0]. Each step computes n = s[6]^s[5], shifts s left taking n in at bit 0, and emits n. The first step's bit lands on bit 31 and the last on bit 0. The state after the 32 steps is kept for the next data word.
- R8: The scrambler state does not change during IDLE words. A data word after an idle gap continues the sequence as if the gap were absent.
- R9: A data-type word with `tx_valid` high and no SYNC since reset is output as IDLE_WORD with `word_scr` 0. It sets `lock_err` and does not advance the scrambler.
- R10: Once set, `lock_err` stays 1 until reset, even after a SYNC word.
- R11: A SYNC in the middle of a data stream restarts the keystream from the all-ones seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 32 | Parallel data word |
| tx_kind | input | 2 | Type code: 00 SYNC, 01/10/11 data |
| tx_valid | input | 1 | Word enable; low sends IDLE |
| word_out | output | 32 | Framed output word |
| word_scr | output | 1 | High when `word_out` is scrambled data |
| lock_err | output | 1 | Sticky: data was offered before any SYNC |

## Verification
A scrambler state that is seeded wrong, steps wrong, or moves during IDLE shows up as a wrong `word_out` on the first data word that follows, one clock after that word is presented. The bench therefore puts data words right after SYNC, after idle gaps, and after a mid-stream SYNC. A wrong armed state shows within one clock as IDLE where data was expected, or as scrambled data with `lock_err` still clear where the block should have refused it.

// File: rtl/txw_pkg.sv
package txw_pkg;

    localparam int DATA_W = 32;
    localparam int KIND_W = 2;
    localparam int LFSR_W = 7;
    localparam int TAP_HI = 7;
    localparam int TAP_LO = 6;
    localparam logic [LFSR_W-1:0] SEED = '1;
    localparam logic [KIND_W-1:0] KIND_SYNC = '0;

    typedef enum logic [1:0] {
        WK_IDLE   = 2'd0,
        WK_SYNC   = 2'd1,
        WK_DATA   = 2'd2,
        WK_ORPHAN = 2'd3
    } word_kind_e;

    typedef struct packed {
        logic [DATA_W-1:0] ks;
        logic [LFSR_W-1:0] next;
    } ks_t;

    // Runs the additive generator DATA_W steps; first bit goes to the MSB.
    function automatic ks_t prbs_run(input logic [LFSR_W-1:0] seed);
        ks_t r;
        logic [LFSR_W-1:0] s;
        logic nb;
        s = seed;
        r.ks = '0;
        for (int i = 0; i < DATA_W; i++) begin
            nb = s[TAP_HI-1] ^ s[TAP_LO-1];
            r.ks[DATA_W-1-i] = nb;
            s = {s[LFSR_W-2:0], nb};
        end
        r.next = s;
        return r;
    endfunction

endpackage

// File: rtl/txw_classify.sv
module txw_classify
    import txw_pkg::*;
(
    input  logic              valid,
    input  logic [KIND_W-1:0] kind,
    input  logic              armed,
    output word_kind_e        wk
);
    always_comb begin
        if (!valid)
            wk = WK_IDLE;
        else if (kind == KIND_SYNC)
            wk = WK_SYNC;
        else if (armed)
            wk = WK_DATA;
        else
            wk = WK_ORPHAN;
    end
endmodule

// File: rtl/txw_scrambler.sv
module txw_scrambler
    import txw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reseed,
    input  logic              advance,
    output logic [DATA_W-1:0] keystream
);
    logic [LFSR_W-1:0] state_q;
    ks_t               run;

    always_comb run = prbs_run(state_q);
    assign keystream = run.ks;

    always_ff @(posedge clk) begin
        if (rst || reseed)
            state_q <= SEED;
        else if (advance)
            state_q <= run.next;
    end
endmodule

// File: rtl/txw_framer.sv
module txw_framer
    import txw_pkg::*;
#(
    parameter logic [DATA_W-1:0] IDLE_WORD = 32'hBC95_BC95,
    parameter logic [DATA_W-1:0] SYNC_WORD = 32'h1F3A_C5E0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [KIND_W-1:0] tx_kind,
    input  logic              tx_valid,
    output logic [DATA_W-1:0] word_out,
    output logic              word_scr,
    output logic              lock_err
);
    logic              armed_q;
    word_kind_e        wk;
    logic [DATA_W-1:0] ks;

    txw_classify u_cls (
        .valid (tx_valid),
        .kind  (tx_kind),
        .armed (armed_q),
        .wk    (wk)
    );

    txw_scrambler u_scr (
        .clk       (clk),
        .rst       (rst),
        .reseed    (wk == WK_SYNC),
        .advance   (wk == WK_DATA),
        .keystream (ks)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            lock_err <= 1'b0;
            word_out <= IDLE_WORD;
            word_scr <= 1'b0;
        end else begin
            unique case (wk)
                WK_SYNC: begin
                    armed_q  <= 1'b1;
                    word_out <= SYNC_WORD;
                    word_scr <= 1'b0;
                end
                WK_DATA: begin
                    word_out <= tx_data ^ ks;
                    word_scr <= 1'b1;
                end
                WK_ORPHAN: begin
                    lock_err <= 1'b1;
                    word_out <= IDLE_WORD;
                    word_scr <= 1'b0;
                end
                default: begin
                    word_out <= IDLE_WORD;
                    word_scr <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/txw_framer_chk.sv
module txw_framer_chk
    import txw_pkg::*;
#(
    parameter logic [DATA_W-1:0] IDLE_WORD = 32'hBC95_BC95,
    parameter logic [DATA_W-1:0] SYNC_WORD = 32'h1F3A_C5E0
) (
    input logic              clk,
    input logic              rst,
    input logic [KIND_W-1:0] tx_kind,
    input logic              tx_valid,
    input logic              armed,
    input logic [DATA_W-1:0] word_out,
    input logic              word_scr,
    input logic              lock_err
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (word_out == IDLE_WORD && !word_scr && !lock_err));

    assert_idle_when_off_R3: assert property (@(posedge clk) disable iff (rst)
        !tx_valid |=> (word_out == IDLE_WORD && !word_scr));

    assert_sync_plain_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_kind == KIND_SYNC) |=> (word_out == SYNC_WORD && !word_scr));

    assert_data_scrambled_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_kind != KIND_SYNC && armed) |=> word_scr);

    assert_orphan_refused_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_kind != KIND_SYNC && !armed) |=>
            (lock_err && word_out == IDLE_WORD && !word_scr));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        lock_err |=> lock_err);
endmodule

bind txw_framer txw_framer_chk #(
    .IDLE_WORD (IDLE_WORD),
    .SYNC_WORD (SYNC_WORD)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_kind  (tx_kind),
    .tx_valid (tx_valid),
    .armed    (armed_q),
    .word_out (word_out),
    .word_scr (word_scr),
    .lock_err (lock_err)
);

// File: tb/tb_txw_framer.sv
module tb_txw_framer;
    localparam int PERIOD = 10;
    localparam logic [31:0] IDLE_W = 32'hBC95_BC95;
    localparam logic [31:0] SYNC_W = 32'h1F3A_C5E0;
    localparam int NV = 16;

    // {valid, kind[1:0], data[31:0]}
    localparam logic [34:0] VEC [NV] = '{
        {1'b1, 2'b01, 32'h1234_5678},   // R9 data before any sync
        {1'b0, 2'b10, 32'hFFFF_0000},   // R3 idle, inputs ignored
        {1'b1, 2'b00, 32'hDEAD_BEEF},   // R4 R5 sync
        {1'b1, 2'b01, 32'h0000_0000},   // R7 raw keystream from seed
        {1'b1, 2'b10, 32'hA5A5_A5A5},   // R6 code 10
        {1'b1, 2'b11, 32'h0F0F_F0F0},   // R6 code 11
        {1'b0, 2'b01, 32'h1111_1111},   // R8 gap
        {1'b0, 2'b00, 32'h2222_2222},   // R3 sync code while disabled
        {1'b1, 2'b01, 32'hCAFE_0001},   // R8 continues sequence
        {1'b1, 2'b00, 32'h0000_0000},   // R11 mid-stream sync
        {1'b1, 2'b11, 32'h0000_0000},   // R11 keystream restarts
        {1'b1, 2'b10, 32'hFFFF_FFFF},
        {1'b1, 2'b01, 32'h8000_0001},
        {1'b0, 2'b11, 32'hFFFF_FFFF},
        {1'b1, 2'b00, 32'h5555_AAAA},
        {1'b1, 2'b10, 32'h7777_8888}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] tx_data = '0;
    logic [1:0]  tx_kind = '0;
    logic        tx_valid = 1'b0;
    logic [31:0] word_out;
    logic        word_scr;
    logic        lock_err;

    int applied = 0;
    int bad = 0;
    bit done = 0;

    logic [6:0] m_st;
    logic       m_armed;
    logic       m_err;

    always #(PERIOD/2) clk = ~clk;

    txw_framer dut (
        .clk(clk), .rst(rst), .tx_data(tx_data), .tx_kind(tx_kind),
        .tx_valid(tx_valid), .word_out(word_out), .word_scr(word_scr),
        .lock_err(lock_err)
    );

    // Independent model of the R7 keystream.
    function automatic logic [31:0] ks_of(input logic [6:0] s0, output logic [6:0] s1);
        logic [31:0] k;
        logic [6:0] s;
        logic n;
        s = s0;
        for (int i = 31; i >= 0; i--) begin
            n = s[6] ^ s[5];
            k[i] = n;
            s = {s[5:0], n};
        end
        s1 = s;
        return k;
    endfunction

    task automatic check(input string req, input logic [31:0] ew, input logic es, input logic ee);
        applied++;
        if (word_out !== ew || word_scr !== es || lock_err !== ee) begin
            bad++;
            $display("FAIL %s: got word=%h scr=%b err=%b, expected word=%h scr=%b err=%b",
                     req, word_out, word_scr, lock_err, ew, es, ee);
        end
    endtask

    // R2: inputs driven at a falling edge, result sampled at the next falling edge.
    task automatic step(input logic v, input logic [1:0] k, input logic [31:0] d, input string req);
        logic [31:0] ew;
        logic es;
        logic [6:0] nx;
        tx_valid = v; tx_kind = k; tx_data = d;
        if (!v) begin
            ew = IDLE_W; es = 0;
        end else if (k == 2'b00) begin
            ew = SYNC_W; es = 0; m_st = 7'h7F; m_armed = 1;
        end else if (m_armed) begin
            ew = d ^ ks_of(m_st, nx); es = 1; m_st = nx;
        end else begin
            ew = IDLE_W; es = 0; m_err = 1;
        end
        @(negedge clk);
        check(req, ew, es, m_err);
    endtask

    task automatic do_reset();
        rst = 1; tx_valid = 0;
        @(negedge clk);
        @(negedge clk);
        check("R1", IDLE_W, 0, 0);
        rst = 0;
        m_st = 7'h7F; m_armed = 0; m_err = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 50000);
        bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        for (int i = 0; i < NV; i++) begin
            string tag;
            if (!VEC[i][34]) tag = "R3";
            else if (VEC[i][33:32] == 2'b00) tag = "R4";
            else if (!m_armed) tag = "R9";
            else tag = "R6";
            step(VEC[i][34], VEC[i][33:32], VEC[i][31:0], tag);
        end

        // R1: reset forgets sync and clears the error; R9 repeats after reset
        do_reset();
        step(1, 2'b11, 32'hABCD_EF01, "R9");
        step(1, 2'b10, 32'h0, "R9");
        // R10: error survives sync and data
        step(1, 2'b00, 32'h0, "R10");
        step(1, 2'b01, 32'h0, "R10");
        step(0, 2'b00, 32'h0, "R10");
        // R5: seed after sync gives 7'h7F keystream, raw data zero
        step(1, 2'b00, 32'h0, "R5");
        step(1, 2'b01, 32'h0, "R5");
        // R8: long gap keeps state
        repeat (5) step(0, 2'b01, 32'hFFFF_FFFF, "R8");
        step(1, 2'b01, 32'h0, "R8");
        do_reset();
        finish_run();
    end
endmodule